// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a small shared word memory and serves several requesting ports. Each port can issue a plain load, a plain store, a load-linked or a store-conditional. A load-linked returns the addressed word and leaves a reservation for that port on the word. A later store-conditional from the same port writes only if nothing has written that word in between. It answers 1 on success and 0 on failure, and that answer takes the place of the store data in the requester's register.

Atomicity does not come from a locked bus cycle. Any completed write to a word clears every port's reservation on that word. A fixed-priority arbiter accepts one request per cycle, so two conditional stores racing for the same word are always ordered. The first one wins and clears the other's reservation. Software builds locks and atomic exchanges from these two operations.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (op code 2) returns the addressed word and reserves that word for the issuing port. A store-conditional (op code 3) from that port to the same word, with no write in between, writes its data and returns 1.
- R2: A store-conditional whose reserved word was written by another port after the load-linked returns 0, and the word keeps the value of the intervening write.
- R3: A store-conditional from a port with no reservation, or with a reservation on a different word, returns 0 and writes nothing.
- R4: Every store-conditional drops its own port's reservation, whether it succeeds or fails, so a second store-conditional without a fresh load-linked returns 0.
- R5: Any completed write to a word clears all ports' reservations on that word. This covers a plain store (op code 1) and a successful store-conditional. Writes to other words leave reservations intact.
- R6: Reservations compare word addresses only. The two low byte-address bits (bits [1:0]) are ignored, and loads and stores act on the whole containing word.
- R7: At most one port is accepted per cycle, and the lowest-numbered valid port wins. Of two same-cycle store-conditionals to one reserved word, the lower-numbered port gets 1 and the other gets 0.
- R8: A response is valid on the accepting port exactly one cycle after acceptance. A load (op code 0) returns the word, and a plain store returns 0.
- R9: Reset clears every memory word to 0 and drops all reservations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORT | Per-port request valid |
| req_ready | output | NPORT | Per-port request accepted this cycle |
| req_op | input | 2*NPORT | Per-port op: 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_addr | input | ADDR_W*NPORT | Per-port byte address |
| req_wdata | input | DATA_W*NPORT | Per-port store data |
| rsp_valid | output | NPORT | Per-port response valid |
| rsp_data | output | DATA_W*NPORT | Per-port load data or conditional result |

## Verification
The bench targets the ways a reservation can be lost: another port's store, a winning conditional store from a rival port, and the port's own earlier conditional store, whether that one passed or failed. A design that misses any of these lets a stale conditional store succeed and overwrite data. It also drives a conditional store at a different byte of the reserved word and one at a different word. A wrong address comparison would then fail the first or pass the second. Two conditional stores racing in one cycle must produce exactly one 1. A reservation held across reset must not survive it.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_prio_arb.sv
// Fixed-priority single-grant arbiter: lowest index wins.
module llsc_prio_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/llsc_resv_table.sv
// One reservation (valid + word index) per port.
module llsc_resv_table
  import llsc_pkg::*;
#(
  parameter int N  = 4,
  parameter int WW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic [IW-1:0]   acc_port,
  input  llsc_op_e        acc_op,
  input  logic [WW-1:0]   acc_word,
  input  logic            wr_en,
  input  logic [WW-1:0]   wr_word,
  output logic            sc_hit,
  output logic [N-1:0]    resv_vld,
  output logic [N*WW-1:0] resv_word
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic          vld_q, vld_d;
    logic [WW-1:0] word_q;
    logic          mine, word_en;

    assign mine    = acc_en && (acc_port == IW'(g));
    assign word_en = mine && (acc_op == OP_LINK);

    always_comb begin
      vld_d = vld_q;
      if (wr_en && vld_q && (word_q == wr_word)) vld_d = 1'b0;
      if (word_en)                               vld_d = 1'b1;
      else if (mine && (acc_op == OP_COND))      vld_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        word_q <= '0;
      end else begin
        vld_q <= vld_d;
        if (word_en) word_q <= acc_word;
      end
    end

    assign resv_vld[g]            = vld_q;
    assign resv_word[g*WW +: WW]  = word_q;
  end

  always_comb begin
    sc_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (acc_port == IW'(i))
        sc_hit = resv_vld[i] && (resv_word[i*WW +: WW] == acc_word);
    end
  end
endmodule

// File: rtl/llsc_word_mem.sv
// Small resettable word store, one write port, one combinational read port.
module llsc_word_mem #(
  parameter int DW = 32,
  parameter int WW = 4,
  localparam int DEPTH = 1 << WW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [WW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [WW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DEPTH*DW-1:0] cells;

  for (genvar w = 0; w < DEPTH; w++) begin : g_cell
    logic [DW-1:0] cell_q;
    logic          cell_en;
    assign cell_en = we && (waddr == WW'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= '0;
      else if (cell_en) cell_q <= wdata;
    end
    assign cells[w*DW +: DW] = cell_q;
  end

  assign rdata = cells[raddr*DW +: DW];
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        req_valid,
  output logic [NPORT-1:0]        req_ready,
  input  logic [2*NPORT-1:0]      req_op,
  input  logic [ADDR_W*NPORT-1:0] req_addr,
  input  logic [DATA_W*NPORT-1:0] req_wdata,
  output logic [NPORT-1:0]        rsp_valid,
  output logic [DATA_W*NPORT-1:0] rsp_data
);
  localparam int IW       = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int WORD_OFS = $clog2(DATA_W / 8);
  localparam int WW       = ADDR_W - WORD_OFS;

  logic [NPORT-1:0]    grant;
  logic [IW-1:0]       gidx;
  logic                gany;
  llsc_op_e            sel_op;
  logic [ADDR_W-1:0]   sel_addr;
  logic [WW-1:0]       sel_word;
  logic [DATA_W-1:0]   sel_wdata;
  logic [DATA_W-1:0]   rd_word;
  logic                sc_hit;
  logic                wr_en;
  logic [DATA_W-1:0]   result;
  logic [NPORT-1:0]    resv_vld;
  logic [NPORT*WW-1:0] resv_word;

  llsc_prio_arb #(.N(NPORT)) u_arb (
    .req   (req_valid),
    .grant (grant),
    .idx   (gidx),
    .any   (gany)
  );

  assign req_ready = grant;
  assign sel_op    = llsc_op_e'(req_op[gidx*2 +: 2]);
  assign sel_addr  = req_addr[gidx*ADDR_W +: ADDR_W];
  assign sel_wdata = req_wdata[gidx*DATA_W +: DATA_W];
  assign sel_word  = sel_addr[ADDR_W-1:WORD_OFS];

  llsc_resv_table #(.N(NPORT), .WW(WW)) u_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (gany),
    .acc_port  (gidx),
    .acc_op    (sel_op),
    .acc_word  (sel_word),
    .wr_en     (wr_en),
    .wr_word   (sel_word),
    .sc_hit    (sc_hit),
    .resv_vld  (resv_vld),
    .resv_word (resv_word)
  );

  assign wr_en = gany && ((sel_op == OP_STORE) || ((sel_op == OP_COND) && sc_hit));

  llsc_word_mem #(.DW(DATA_W), .WW(WW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (sel_word),
    .wdata (sel_wdata),
    .raddr (sel_word),
    .rdata (rd_word)
  );

  always_comb begin
    unique case (sel_op)
      OP_LOAD, OP_LINK: result = rd_word;
      OP_STORE:         result = '0;
      default:          result = DATA_W'(sc_hit);
    endcase
  end

  // Response registers: next-state then register process.
  logic [NPORT-1:0]        rsp_valid_d;
  logic [NPORT-1:0]        rsp_valid_q;
  logic [DATA_W*NPORT-1:0] rsp_data_q;

  always_comb rsp_valid_d = grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= '0;
    else        rsp_valid_q <= rsp_valid_d;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rsp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rsp_data_q[p*DATA_W +: DATA_W] <= '0;
      else if (grant[p]) rsp_data_q[p*DATA_W +: DATA_W] <= result;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
  import llsc_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int WW = AW - $clog2(DW / 8)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    req_valid,
  input logic [N-1:0]    req_ready,
  input logic [2*N-1:0]  req_op,
  input logic [N-1:0]    rsp_valid,
  input logic [N*DW-1:0] rsp_data,
  input logic            mem_we,
  input logic [WW-1:0]   mem_wword,
  input logic [N-1:0]    resv_vld,
  input logic [N*WW-1:0] resv_word
);
  logic [N-1:0]  acc_q, cond_q, cond_d;
  logic          we_q, rd_acc;
  logic [WW-1:0] wword_q;

  always_comb begin
    rd_acc = 1'b0;
    cond_d = '0;
    for (int i = 0; i < N; i++) begin
      if (req_valid[i] && req_ready[i]) begin
        if ((llsc_op_e'(req_op[2*i +: 2]) == OP_LOAD) ||
            (llsc_op_e'(req_op[2*i +: 2]) == OP_LINK)) rd_acc = 1'b1;
        if (llsc_op_e'(req_op[2*i +: 2]) == OP_COND) cond_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cond_q  <= '0;
      we_q    <= 1'b0;
      wword_q <= '0;
    end else begin
      acc_q   <= req_valid & req_ready;
      cond_q  <= cond_d;
      we_q    <= mem_we;
      wword_q <= mem_wword;
    end
  end

  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_ready));
  p_ready_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  p_rsp_timing_r8: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid == acc_q);
  p_read_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n) rd_acc |-> !mem_we);

  for (genvar i = 0; i < N; i++) begin : g_port
    p_sc_binary_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[i] && cond_q[i]) |-> (rsp_data[i*DW +: DW] <= DW'(1)));
    p_sc_win_writes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[i] && cond_q[i] && rsp_data[i*DW +: DW] == DW'(1)) |-> we_q);
    p_sc_lose_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[i] && cond_q[i] && rsp_data[i*DW +: DW] == '0) |-> !we_q);
    p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |-> !(resv_vld[i] && resv_word[i*WW +: WW] == wword_q));
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(.N(NPORT), .AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .mem_we    (wr_en),
  .mem_wword (sel_word),
  .resv_vld  (resv_vld),
  .resv_word (resv_word)
);

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
  localparam int NP = 4;
  localparam int AW = 6;
  localparam int DW = 32;

  logic             clk;
  logic             rst_n;
  logic [NP-1:0]    req_valid;
  logic [NP-1:0]    req_ready;
  logic [2*NP-1:0]  req_op;
  logic [AW*NP-1:0] req_addr;
  logic [DW*NP-1:0] req_wdata;
  logic [NP-1:0]    rsp_valid;
  logic [DW*NP-1:0] rsp_data;

  llsc_monitor #(.NPORT(NP), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int          qp[$];
  logic [31:0] qd[$];
  string       qt[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;

  task automatic drive(int p, logic [1:0] op, logic [5:0] a, logic [31:0] d);
    req_valid[p]           = 1'b1;
    req_op[2*p +: 2]       = op;
    req_addr[AW*p +: AW]   = a;
    req_wdata[DW*p +: DW]  = d;
  endtask

  task automatic issue(int p, logic [1:0] op, logic [5:0] a, logic [31:0] d,
                       logic [31:0] exp, string tag);
    @(negedge clk);
    drive(p, op, a, d);
    #1;
    while (!req_ready[p]) begin
      @(negedge clk);
      #1;
    end
    qp.push_back(p); qd.push_back(exp); qt.push_back(tag);
    @(posedge clk);
    #1 req_valid[p] = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid != '0) begin
      int p;
      p = 0;
      for (int i = 0; i < NP; i++) if (rsp_valid[i]) p = i;
      if ($countones(rsp_valid) > 1) check("R7 one response per cycle", 32'(rsp_valid), 32'(1 << p));
      if (qp.size() == 0) begin
        check("R8 unexpected response", 32'(rsp_valid), 32'h0);
      end else begin
        int          ep;
        logic [31:0] ed;
        string       et;
        ep = qp.pop_front(); ed = qd.pop_front(); et = qt.pop_front();
        check({et, " port"}, 32'(p), 32'(ep));
        check(et, rsp_data[DW*p +: DW], ed);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 rsp_valid after reset", 32'(rsp_valid), 32'h0);

    issue(0, LD, 6'h04, 0, 32'h0, "R9 memory cleared");
    issue(1, SC, 6'h04, 32'h5, 32'h0, "R3 no reservation fails");
    issue(1, LD, 6'h04, 0, 32'h0, "R3 failed SC wrote nothing");
    issue(0, ST, 6'h04, 32'h11, 32'h0, "R8 store returns 0");
    issue(2, LD, 6'h04, 0, 32'h11, "R8 load returns word");

    issue(1, LL, 6'h04, 0, 32'h11, "R1 LL returns word");
    issue(1, SC, 6'h04, 32'h22, 32'h1, "R1 SC succeeds");
    issue(0, LD, 6'h04, 0, 32'h22, "R1 SC wrote data");
    issue(1, SC, 6'h04, 32'h33, 32'h0, "R4 repeat SC after success fails");
    issue(0, LD, 6'h04, 0, 32'h22, "R4 no write");

    issue(2, LL, 6'h08, 0, 32'h0, "R2 LL");
    issue(3, ST, 6'h08, 32'h44, 32'h0, "R2 intervening store");
    issue(2, SC, 6'h08, 32'h55, 32'h0, "R2 SC fails after store");
    issue(2, LD, 6'h08, 0, 32'h44, "R2 intervening value kept");

    issue(2, LL, 6'h0C, 0, 32'h0, "R5 LL");
    issue(3, ST, 6'h10, 32'h7, 32'h0, "R5 store other word");
    issue(2, SC, 6'h0C, 32'h9, 32'h1, "R5 other-word store keeps reservation");
    issue(2, LD, 6'h0C, 0, 32'h9, "R5 SC wrote");

    issue(0, LL, 6'h14, 0, 32'h0, "R5 LL p0");
    issue(1, LL, 6'h14, 0, 32'h0, "R5 LL p1");
    issue(0, SC, 6'h14, 32'h66, 32'h1, "R5 first SC wins");
    issue(1, SC, 6'h14, 32'h77, 32'h0, "R5 SC write clears rival");
    issue(3, LD, 6'h14, 0, 32'h66, "R5 winner value");

    issue(3, LL, 6'h18, 0, 32'h0, "R6 LL");
    issue(3, SC, 6'h1B, 32'hAB, 32'h1, "R6 other byte same word succeeds");
    issue(0, LD, 6'h19, 0, 32'hAB, "R6 whole word read");

    issue(0, LL, 6'h1C, 0, 32'h0, "R3 LL p0");
    issue(1, LL, 6'h20, 0, 32'h0, "R3 LL p1 other word");
    issue(1, SC, 6'h1C, 32'h1, 32'h0, "R3 SC to unreserved word fails");

    issue(2, LL, 6'h24, 0, 32'h0, "R4 LL");
    issue(2, SC, 6'h28, 32'h3, 32'h0, "R4 SC wrong word fails");
    issue(2, SC, 6'h24, 32'h3, 32'h0, "R4 failed SC dropped reservation");

    // Same-cycle race
    issue(1, LL, 6'h2C, 0, 32'h0, "R7 LL p1");
    issue(3, LL, 6'h2C, 0, 32'h0, "R7 LL p3");
    @(negedge clk);
    drive(1, SC, 6'h2C, 32'hC1);
    drive(3, SC, 6'h2C, 32'hC3);
    #1;
    check("R7 lowest port granted", 32'(req_ready), 32'h2);
    qp.push_back(1); qd.push_back(32'h1); qt.push_back("R7 low port SC wins");
    qp.push_back(3); qd.push_back(32'h0); qt.push_back("R7 high port SC loses");
    @(posedge clk);
    #1 req_valid[1] = 1'b0;
    @(negedge clk);
    #1;
    check("R7 second port granted next", 32'(req_ready), 32'h8);
    @(posedge clk);
    #1 req_valid[3] = 1'b0;
    issue(0, LD, 6'h2C, 0, 32'hC1, "R7 winner data");

    // Reset clears reservations and memory
    issue(0, LL, 6'h30, 0, 32'h0, "R9 LL before reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    issue(0, SC, 6'h30, 32'h9, 32'h0, "R9 reservation dropped by reset");
    issue(1, LD, 6'h04, 0, 32'h0, "R9 memory cleared by reset");

    repeat (4) @(negedge clk);
    check("R8 all responses received", 32'(qp.size()), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule